// File: doc/BRIEF.md
# Split-Mode Timer Output-Compare Unit

This block is a timer output-compare unit built on one 16-bit up-counter and one 16-bit compare register. A mode bit in the control register sets how the two are used. With the bit clear, they act as one 16-bit counter and compare pair. With the bit set, the same storage becomes two independent 8-bit counter and compare channels, one on the upper byte and one on the lower byte. Each channel has its own counting enable, compare flag, interrupt-request flag, interrupt enable and toggle output pin.

Software reaches the block through an 8-bit register port. Reads return data combinationally in the cycle `bus_rd` is high, and the read side effects take place at the closing clock edge. In 16-bit mode, a shared temporary byte makes every 16-bit access atomic: the upper byte goes first and the lower byte second, for reads and for writes. The prescaled count enables come from outside the block. Interrupt outputs are plain levels.

Register map (3-bit address):

| Address | Register | Notes |
|---|---|---|
| 0 | counter, upper byte | |
| 1 | counter, lower byte | |
| 2 | compare, upper byte | |
| 3 | compare, lower byte | |
| 4 | control | bit0 split mode, bit1 lower-channel interrupt enable, bit2 upper-channel interrupt enable, bit3 lower-channel pin level, bit4 upper-channel pin level |
| 5 | status | bit0 lower compare flag, bit1 upper compare flag, bit2 lower interrupt request, bit3 upper interrupt request |

Any other address reads as 0.

Top module: `split_cmp_timer`

## Requirements
- R1: After reset the compare register reads 0xFFFF. The counter, control and status registers read 0. Both pins and both interrupt outputs are 0.
- R2: In 16-bit mode (control bit0 = 0) the counter advances by one on each cycle with `tick_lo` high, carrying from the lower byte into the upper byte and wrapping from 0xFFFF to 0x0000. `tick_hi` has no effect in this mode.
- R3: In split mode (control bit0 = 1) the lower byte advances on `tick_lo` and wraps from 0xFF to 0x00 with no carry. The upper byte advances only on `tick_hi`.
- R4: In 16-bit mode, when the counter advances onto a value equal to the full 16-bit compare register, status bit1 and status bit3 are set at that clock edge and `pin_hi` toggles. The lower channel (status bit0, bit2, `pin_lo`) is unaffected. A CPU write of an equal value to the counter is not a match.
- R5: In split mode each byte of the counter is compared only with the same byte of the compare register. A lower-byte match sets status bit0 and bit2 and toggles `pin_lo`. An upper-byte match sets status bit1 and bit3 and toggles `pin_hi`.
- R6: Each pin inverts on every match of its channel. Any write to the control register loads `pin_hi` from bit4 and `pin_lo` from bit3.
- R7: `irq_hi` is high exactly when status bit3 and control bit2 are both 1. `irq_lo` is high exactly when status bit2 and control bit1 are both 1.
- R8: In 16-bit mode, a write to an upper-byte address (0 or 2) loads only the temporary byte. A following write to the matching lower-byte address (1 or 3) loads all 16 bits from the temporary byte and the written data in one cycle.
- R9: In 16-bit mode, a read of address 0 or 2 returns the upper byte and captures the lower byte into the temporary byte. A read of address 1 or 3 returns the temporary byte, even if the counter has advanced since.
- R10: In split mode every counter and compare byte is read and written directly, and the temporary byte is not used.
- R11: A compare flag is cleared by writing 0 to its status bit, but only after the status register has been read with that flag at 1. A clear with no such read leaves the flag at 1. A match in the same cycle as the clear keeps the flag at 1.
- R12: An interrupt-request flag (status bit2 or bit3) is cleared by writing 0 to its bit, with no read needed. Writing 1 to any status bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_hi | input | 1 | Count enable of the upper byte in split mode |
| tick_lo | input | 1 | Count enable of the lower byte, or of the whole counter in 16-bit mode |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| pin_hi | output | 1 | Toggle output of the upper (or 16-bit) channel |
| pin_lo | output | 1 | Toggle output of the lower channel |
| irq_hi | output | 1 | Interrupt of the upper (or 16-bit) channel |
| irq_lo | output | 1 | Interrupt of the lower channel |

## Verification
A software clear of a compare flag can land in the same cycle as a new compare match, and the two must resolve in favour of the match. The bench parks the counter one step below the compare value. It then drives `tick_lo` together with a status write that tries to clear the armed flag, all in one cycle. The result is judged at the ports: the status must still show the flag, the pin must have toggled, and the clear must be spent, so that a second clear takes effect only after a new read of the status register.

// File: rtl/tmr_split_pkg.sv
`timescale 1ns/1ps
package tmr_split_pkg;
  localparam int ADDR_W = 3;
  // register addresses
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  // control bits; channel 0 = lower byte, channel 1 = upper byte
  localparam int CTL_W     = 5;
  localparam int CTL_SPLIT = 0;
  localparam int CTL_IE0   = 1;
  localparam int CTL_LVL0  = 3;
  // status bits
  localparam int ST_FLAG0  = 0;
  localparam int ST_IRQ0   = 2;
  localparam int N_CH      = 2;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  split,
  input  logic                  tick_hi,
  input  logic                  tick_lo,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [2*BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0]   cnt,
  output logic [2*BYTE_W-1:0]   nxt,
  output logic [1:0]            adv
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    nxt = cnt;
    adv = 2'b00;
    if (split) begin
      if (tick_lo) begin
        nxt[BYTE_W-1:0] = cnt[BYTE_W-1:0] + BYTE_W'(1);
        adv[0] = 1'b1;
      end
      if (tick_hi) begin
        nxt[CNT_W-1:BYTE_W] = cnt[CNT_W-1:BYTE_W] + BYTE_W'(1);
        adv[1] = 1'b1;
      end
    end else if (tick_lo) begin
      nxt    = cnt + CNT_W'(1);
      adv[0] = 1'b1;
    end
    cnt_d = nxt;
    // a CPU write to a byte wins over counting and is never a match
    if (wr_hi) begin
      cnt_d[CNT_W-1:BYTE_W] = wdata[CNT_W-1:BYTE_W];
      adv[1] = 1'b0;
    end
    if (wr_lo) begin
      cnt_d[BYTE_W-1:0] = wdata[BYTE_W-1:0];
      adv[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && tick_lo && !wr_lo && !wr_hi && (&cnt)) |=> (cnt == '0)); // R2

  AST_SPLIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (split && tick_lo && !tick_hi && !wr_hi) |=>
      $stable(cnt[CNT_W-1:BYTE_W])); // R3
endmodule

// File: rtl/tmr_match.sv
`timescale 1ns/1ps
module tmr_match #(
  parameter int BYTE_W = 8
) (
  input  logic                  split,
  input  logic [1:0]            adv,
  input  logic [2*BYTE_W-1:0]   nxt,
  input  logic [2*BYTE_W-1:0]   cmp,
  output logic [1:0]            hit
);
  localparam int CNT_W = 2 * BYTE_W;

  always_comb begin
    hit = 2'b00;
    if (split) begin
      hit[0] = adv[0] && (nxt[BYTE_W-1:0] == cmp[BYTE_W-1:0]);
      hit[1] = adv[1] && (nxt[CNT_W-1:BYTE_W] == cmp[CNT_W-1:BYTE_W]);
    end else begin
      hit[1] = adv[0] && (nxt == cmp);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ie,
  input  logic lvl_wr,
  input  logic lvl_val,
  input  logic stat_rd,
  input  logic flag_wr0,
  input  logic irq_wr0,
  output logic flag,
  output logic irqf,
  output logic pin,
  output logic irq
);
  logic armed, armed_d, flag_d, irqf_d, pin_d;

  always_comb begin
    flag_d  = hit | (flag & ~(flag_wr0 & armed));
    irqf_d  = hit | (irqf & ~irq_wr0);
    armed_d = armed;
    if (flag_wr0)            armed_d = 1'b0;
    else if (stat_rd && flag) armed_d = 1'b1;
    pin_d = pin;
    if (lvl_wr)   pin_d = lvl_val;
    else if (hit) pin_d = ~pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      irqf  <= 1'b0;
      armed <= 1'b0;
      pin   <= 1'b0;
    end else begin
      flag  <= flag_d;
      irqf  <= irqf_d;
      armed <= armed_d;
      pin   <= pin_d;
    end
  end

  assign irq = irqf & ie;

  AST_HIT_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (flag && irqf)); // R5

  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lvl_wr) |=> (pin != $past(pin))); // R6

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_wr0 && armed && !hit)); // R11
endmodule

// File: rtl/split_cmp_timer.sv
`timescale 1ns/1ps
module split_cmp_timer
  import tmr_split_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_hi,
  input  logic                tick_lo,
  input  logic [2:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                pin_hi,
  output logic                pin_lo,
  output logic                irq_hi,
  output logic                irq_lo
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cmp, cmp_d, cnt, nxt, wide_data;
  logic [BYTE_W-1:0] tmp, tmp_d, stat_v;
  logic [CTL_W-1:0]  ctrl, ctrl_d;
  logic [1:0]        adv, hit;
  logic [N_CH-1:0]   flag, irqf, pin, irq;
  logic              split, ctrl_wr, stat_wr, stat_rd;
  logic              cnt_wr_hi, cnt_wr_lo, cmp_wr_hi, cmp_wr_lo;

  assign split   = ctrl[CTL_SPLIT];
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  // 16-bit mode: lower-byte write commits both bytes; split: per byte
  always_comb begin
    cnt_wr_lo = bus_wr && (bus_addr == A_CNT_LO);
    cmp_wr_lo = bus_wr && (bus_addr == A_CMP_LO);
    cnt_wr_hi = split ? (bus_wr && (bus_addr == A_CNT_HI)) : cnt_wr_lo;
    cmp_wr_hi = split ? (bus_wr && (bus_addr == A_CMP_HI)) : cmp_wr_lo;
    wide_data = split ? {bus_wdata, bus_wdata} : {tmp, bus_wdata};
  end

  // compare register, temporary byte and control: next state
  always_comb begin
    cmp_d = cmp;
    if (cmp_wr_hi) cmp_d[CNT_W-1:BYTE_W] = wide_data[CNT_W-1:BYTE_W];
    if (cmp_wr_lo) cmp_d[BYTE_W-1:0]     = wide_data[BYTE_W-1:0];
    tmp_d = tmp;
    if (!split) begin
      if (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CMP_HI))
        tmp_d = bus_wdata;
      else if (bus_rd && bus_addr == A_CNT_HI)
        tmp_d = cnt[BYTE_W-1:0];
      else if (bus_rd && bus_addr == A_CMP_HI)
        tmp_d = cmp[BYTE_W-1:0];
    end
    ctrl_d = ctrl_wr ? bus_wdata[CTL_W-1:0] : ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '1;
      tmp  <= '0;
      ctrl <= '0;
    end else begin
      cmp  <= cmp_d;
      tmp  <= tmp_d;
      ctrl <= ctrl_d;
    end
  end

  tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .split(split),
    .tick_hi(tick_hi), .tick_lo(tick_lo),
    .wr_hi(cnt_wr_hi), .wr_lo(cnt_wr_lo), .wdata(wide_data),
    .cnt(cnt), .nxt(nxt), .adv(adv)
  );

  tmr_match #(.BYTE_W(BYTE_W)) u_match (
    .split(split), .adv(adv), .nxt(nxt), .cmp(cmp), .hit(hit)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .hit(hit[i]),
      .ie(ctrl[CTL_IE0+i]),
      .lvl_wr(ctrl_wr), .lvl_val(bus_wdata[CTL_LVL0+i]),
      .stat_rd(stat_rd),
      .flag_wr0(stat_wr && !bus_wdata[ST_FLAG0+i]),
      .irq_wr0(stat_wr && !bus_wdata[ST_IRQ0+i]),
      .flag(flag[i]), .irqf(irqf[i]), .pin(pin[i]), .irq(irq[i])
    );
  end

  // read path
  always_comb begin
    stat_v = '0;
    stat_v[ST_FLAG0+1:ST_FLAG0] = flag;
    stat_v[ST_IRQ0+1:ST_IRQ0]   = irqf;
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
        A_CNT_LO: bus_rdata = split ? cnt[BYTE_W-1:0] : tmp;
        A_CMP_HI: bus_rdata = cmp[CNT_W-1:BYTE_W];
        A_CMP_LO: bus_rdata = split ? cmp[BYTE_W-1:0] : tmp;
        A_CTRL:   bus_rdata = BYTE_W'(ctrl);
        A_STAT:   bus_rdata = stat_v;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_hi = pin[1];
  assign pin_lo = pin[0];
  assign irq_hi = irq[1];
  assign irq_lo = irq[0];

  AST_LO_QUIET_16: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !ctrl_wr) |=> ($stable(pin_lo) && !$rose(flag[0]))); // R4

  AST_HI_WR_TEMP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && bus_wr && bus_addr == A_CMP_HI) |=> $stable(cmp)); // R8

  AST_LO_WR_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && bus_wr && bus_addr == A_CMP_LO) |=>
      (cmp == {$past(tmp), $past(bus_wdata)})); // R8
endmodule

// File: tb/split_cmp_timer_tb.sv
`timescale 1ns/1ps
module split_cmp_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_hi = 1'b0, tick_lo = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pin_hi, pin_lo, irq_hi, irq_lo;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  split_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_hi(tick_hi), .tick_lo(tick_lo),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_hi(pin_hi), .pin_lo(pin_lo), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  // addresses: 0 cnt hi, 1 cnt lo, 2 cmp hi, 3 cmp lo, 4 ctrl, 5 stat
  // vector: [19] write, [18:16] addr, [15:8] wdata, [7:0] expected read
  localparam int NV = 21;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd2, 8'h12, 8'h00}, {1'b1, 3'd3, 8'h34, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h12}, {1'b0, 3'd3, 8'h00, 8'h34},
    {1'b1, 3'd2, 8'h56, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h12}, {1'b0, 3'd3, 8'h00, 8'h34},
    {1'b1, 3'd4, 8'h01, 8'h00}, {1'b1, 3'd3, 8'h77, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h77}, {1'b0, 3'd2, 8'h00, 8'h12},
    {1'b1, 3'd2, 8'h88, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h88},
    {1'b1, 3'd4, 8'h00, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h88},
    {1'b0, 3'd3, 8'h00, 8'h77}, {1'b1, 3'd0, 8'hAB, 8'h00},
    {1'b1, 3'd1, 8'hCD, 8'h00}, {1'b0, 3'd0, 8'h00, 8'hAB},
    {1'b0, 3'd1, 8'h00, 8'hCD}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tick(input logic hi, input logic lo, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_hi = hi; tick_lo = lo;
      @(negedge clk);
      tick_hi = 1'b0; tick_lo = 1'b0;
    end
  endtask

  task automatic pins(input string tag, input logic ph, input logic pl,
                      input logic ih, input logic il);
    chk(tag, {4'b0, pin_hi, pin_lo, irq_hi, irq_lo}, {4'b0, ph, pl, ih, il});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    pins("R1 outputs", 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk("R1 cmp hi", 3'd2, 8'hFF);
    rd_chk("R1 cmp lo", 3'd3, 8'hFF);
    rd_chk("R1 cnt hi", 3'd0, 8'h00);
    rd_chk("R1 cnt lo", 3'd1, 8'h00);
    rd_chk("R1 ctrl", 3'd4, 8'h00);
    rd_chk("R1 stat", 3'd5, 8'h00);

    // R8/R9/R10 access vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rd_chk("R8/R9/R10 vector", VEC[i][18:16], VEC[i][7:0]);
    end

    // R9 lower byte read returns the captured value after counting
    rd_chk("R9 hi read", 3'd0, 8'hAB);
    tick(1'b0, 1'b1, 1);
    rd_chk("R9 latched lo", 3'd1, 8'hCD);
    rd_chk("R9 fresh hi", 3'd0, 8'hAB);
    rd_chk("R9 fresh lo", 3'd1, 8'hCE);

    // R2 carry, tick_hi ignored, wrap
    wr(3'd0, 8'h12); wr(3'd1, 8'hFF);
    tick(1'b0, 1'b1, 1);
    rd_chk("R2 carry hi", 3'd0, 8'h13);
    rd_chk("R2 carry lo", 3'd1, 8'h00);
    tick(1'b1, 1'b0, 2);
    rd_chk("R2 tick_hi ignored hi", 3'd0, 8'h13);
    rd_chk("R2 tick_hi ignored lo", 3'd1, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    tick(1'b0, 1'b1, 1);
    rd_chk("R2 wrap hi", 3'd0, 8'h00);
    rd_chk("R2 wrap lo", 3'd1, 8'h00);

    // R4 16-bit match, R6 toggle, R7 gating
    wr(3'd2, 8'h13); wr(3'd3, 8'h00);
    wr(3'd0, 8'h12); wr(3'd1, 8'hFE);
    tick(1'b0, 1'b1, 1);
    rd_chk("R4 before match", 3'd5, 8'h00);
    tick(1'b0, 1'b1, 1);
    rd_chk("R4 match stat", 3'd5, 8'h0A);
    pins("R4 R6 R7 pins after match", 1'b1, 1'b0, 1'b0, 1'b0);
    wr(3'd4, 8'h14);
    pins("R7 irq enabled", 1'b1, 1'b0, 1'b1, 1'b0);

    // R11 armed clear, R12 irq clear
    wr(3'd5, 8'h00);
    rd_chk("R11 R12 cleared", 3'd5, 8'h00);
    pins("R12 irq dropped", 1'b1, 1'b0, 1'b0, 1'b0);
    wr(3'd0, 8'h12); wr(3'd1, 8'hFF);
    tick(1'b0, 1'b1, 1);
    pins("R6 second toggle", 1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd5, 8'h08);
    rd_chk("R11 clear without read ignored", 3'd5, 8'h0A);
    wr(3'd0, 8'h12); wr(3'd1, 8'hFF);
    @(negedge clk);
    tick_lo = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk);
    tick_lo = 1'b0; bus_wr = 1'b0;
    rd_chk("R11 set wins over clear", 3'd5, 8'h0A);
    pins("R11 R6 toggle in clear cycle", 1'b1, 1'b0, 1'b1, 1'b0);
    wr(3'd5, 8'h08);
    rd_chk("R11 clear after read", 3'd5, 8'h08);
    wr(3'd5, 8'h00);
    rd_chk("R12 irq flag clear", 3'd5, 8'h00);

    // R3 / R5 split mode
    wr(3'd4, 8'h07);
    pins("R6 ctrl write loads pins", 1'b0, 1'b0, 1'b0, 1'b0);
    wr(3'd2, 8'h05); wr(3'd3, 8'h03);
    wr(3'd0, 8'h03); wr(3'd1, 8'hFF);
    tick(1'b0, 1'b1, 1);
    rd_chk("R3 no carry hi", 3'd0, 8'h03);
    rd_chk("R3 lo wrapped", 3'd1, 8'h00);
    tick(1'b0, 1'b1, 3);
    rd_chk("R5 lo match stat", 3'd5, 8'h05);
    pins("R5 lo channel", 1'b0, 1'b1, 1'b0, 1'b1);
    tick(1'b1, 1'b0, 2);
    rd_chk("R5 hi match stat", 3'd5, 8'h0F);
    pins("R5 hi channel", 1'b1, 1'b1, 1'b1, 1'b1);
    rd_chk("R3 hi byte own enable", 3'd0, 8'h05);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule